// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block keeps the status, interrupt and configuration state of a NAND-style flash command interface. A register bus writes and reads five registers: an error status register (read-only), an interrupt register, two configuration words and the command code. A command datapath reports each finished operation as a one-cycle strobe that carries a kind code and an error flag. The block folds each report into the interrupt and status registers.

The block drives an interrupt line whose polarity comes from a configuration bit, and a ready line that follows another configuration bit. A command write is refused while the master interrupt bit is set, so software must acknowledge one operation before it starts the next. Known command codes are passed on to the datapath as a one-cycle issue pulse. Unknown codes are flagged as an error in this block and are not passed on.

Top module: `flash_irq_status_ctrl`

## Requirements
- R1: After the asynchronous reset the registers read as follows: status 0x0000, interrupt 0x8080, configuration 1 0x40C0, configuration 2 0x0000, command 0x0000. Both rdy_o and irq_o are 1.
- R2: A warm reset sets interrupt to 0x8010, configuration 1 to 0x40C0, and configuration 2, status and command to zero. It also sets rdy_o to 1. A warm reset comes from a warm_rst_i pulse or from a completion of kind 3 (reset).
- R3: A completion that is not a reset ORs bit 15 into the interrupt register, plus one done bit for its kind. Kind 0 (load) sets bit 7, kind 1 (program) sets bit 6, kind 2 (erase) sets bit 5 and kind 4 (other) sets no extra bit.
- R4: A failed completion sets status bit 10 (command error) and the error bit of its own kind. Load sets bit 13, program sets bit 12 and erase sets bit 11. Kind other sets only bit 10.
- R5: A write to the interrupt register (address 1) ANDs the written value into it. If bit 15 of the result is zero, status bits 13 to 10 are cleared.
- R6: A write to the command register (address 4) is ignored while interrupt bit 15 is set. The stored code does not change and no issue pulse is given.
- R7: An accepted command write stores the code. A known code raises cmd_issue_o for one cycle. Known codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x94, 0x95, 0xB0, 0xF0 and 0xF3. Any other code sets status bit 10 and interrupt bit 15 and gives no issue pulse.
- R8: irq_o equals interrupt bit 15 XOR the inverse of configuration 1 bit 6. It is registered, so it follows its inputs one clock later.
- R9: A write to configuration 1 (address 2) drives rdy_o from written bit 7 on the next cycle. Reading configuration 1 returns its value with bits 4..0 forced to zero. Configuration 2 (address 3) reads back whole.
- R10: When a completion and a bus write fall in the same cycle, the bus write is applied to the result of the completion. This includes the master-bit test for command acceptance.
- R11: Writes to the status register (address 0) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | One-cycle warm reset request |
| done_valid_i | input | 1 | Completion strobe |
| done_kind_i | input | 3 | Completion kind: 0 load, 1 program, 2 erase, 3 reset, 4 other |
| done_err_i | input | 1 | Completion failed |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 status, 1 interrupt, 2 cfg1, 3 cfg2, 4 command |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address, same map |
| rd_data_o | output | 16 | Read data (combinational) |
| cmd_issue_o | output | 1 | One-cycle pulse for an accepted known command |
| cmd_code_o | output | 16 | Stored command code |
| irq_o | output | 1 | Interrupt line with selectable polarity |
| rdy_o | output | 1 | Ready line |

## Verification
A completion report and a register-bus write can land in the same clock. The bench drives both strobes in one cycle in three cases. The first pairs a failed completion with an interrupt acknowledge of zero; both the interrupt and error bits must end up clear. The second pairs a load completion with a command write; the write must be refused because the completion has just set the master bit. The third pairs a reset completion with a configuration write; the written value must survive the reset. Each case is judged by reading the registers and sampling the issue and ready outputs on the following cycle.

// File: rtl/fics_pkg.sv
package fics_pkg;

  typedef enum logic [2:0] {
    DONE_LOAD  = 3'd0,
    DONE_PROG  = 3'd1,
    DONE_ERASE = 3'd2,
    DONE_RESET = 3'd3,
    DONE_OTHER = 3'd4
  } done_kind_e;

  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_INTR   = 3'd1,
    RA_CFG1   = 3'd2,
    RA_CFG2   = 3'd3,
    RA_CMD    = 3'd4
  } reg_addr_e;

  // interrupt register bits
  localparam int unsigned B_MASTER   = 15;
  localparam int unsigned B_RST_DONE = 4;
  localparam int unsigned B_ERS_DONE = 5;
  localparam int unsigned B_PRG_DONE = 6;
  localparam int unsigned B_LD_DONE  = 7;
  // status register bits
  localparam int unsigned B_ERR_CMD  = 10;
  localparam int unsigned B_ERR_ERS  = 11;
  localparam int unsigned B_ERR_PRG  = 12;
  localparam int unsigned B_ERR_LD   = 13;
  // configuration 1 bits
  localparam int unsigned B_POL      = 6;
  localparam int unsigned B_RDY      = 7;

  localparam logic [15:0] ERR_MASK = 16'h3C00;

  function automatic logic code_known(input logic [15:0] c);
    logic k;
    k = 1'b0;
    if (c[15:8] == 8'h00) begin
      case (c[7:0])
        8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A,
        8'h2C, 8'h30, 8'h65, 8'h71, 8'h94, 8'h95, 8'hB0, 8'hF0,
        8'hF3:   k = 1'b1;
        default: k = 1'b0;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/fics_evt_merge.sv
module fics_evt_merge
  import fics_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         done_valid,
  input  logic [2:0]   done_kind,
  input  logic         done_err,
  output logic [W-1:0] int_set,
  output logic [W-1:0] stat_set,
  output logic         evt_rst
);
  done_kind_e kind;
  assign kind = done_kind_e'(done_kind);

  always_comb begin
    int_set  = '0;
    stat_set = '0;
    evt_rst  = 1'b0;
    if (done_valid) begin
      case (kind)
        DONE_LOAD: begin
          int_set[B_LD_DONE] = 1'b1;
          stat_set[B_ERR_LD] = done_err;
        end
        DONE_PROG: begin
          int_set[B_PRG_DONE] = 1'b1;
          stat_set[B_ERR_PRG] = done_err;
        end
        DONE_ERASE: begin
          int_set[B_ERS_DONE] = 1'b1;
          stat_set[B_ERR_ERS] = done_err;
        end
        DONE_RESET: evt_rst = 1'b1;
        default: ;
      endcase
      if (kind != DONE_RESET) begin
        int_set[B_MASTER]   = 1'b1;
        stat_set[B_ERR_CMD] = done_err;
      end
    end
  end
endmodule

// File: rtl/fics_cmd_gate.sv
module fics_cmd_gate
  import fics_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         wr_cmd,
  input  logic [W-1:0] code,
  input  logic         master_mid,
  output logic         take,
  output logic         issue,
  output logic         unknown
);
  logic known;
  assign known   = code_known(code);
  assign take    = wr_cmd & ~master_mid;
  assign issue   = take & known;
  assign unknown = take & ~known;
endmodule

// File: rtl/fics_irq_drv.sv
module fics_irq_drv #(
  parameter logic IRQ_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic pol,
  output logic irq_o
);
  logic irq_n, irq_q;

  always_comb irq_n = master ^ ~pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= IRQ_RST;
    else        irq_q <= irq_n;
  end

  assign irq_o = irq_q;

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == ($past(master) ^ ~$past(pol))));
endmodule

// File: rtl/flash_irq_status_ctrl.sv
module flash_irq_status_ctrl
  import fics_pkg::*;
#(
  parameter int unsigned  W         = 16,
  parameter logic [15:0]  CFG1_RST  = 16'h40C0,
  parameter logic [15:0]  INT_COLD  = 16'h8080,
  parameter logic [15:0]  INT_WARM  = 16'h8010,
  parameter logic [15:0]  CFG1_RDMK = 16'hFFE0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm_rst_i,
  input  logic         done_valid_i,
  input  logic [2:0]   done_kind_i,
  input  logic         done_err_i,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_addr_i,
  input  logic [15:0]  wr_data_i,
  input  logic [2:0]   rd_addr_i,
  output logic [15:0]  rd_data_o,
  output logic         cmd_issue_o,
  output logic [15:0]  cmd_code_o,
  output logic         irq_o,
  output logic         rdy_o
);
  localparam logic IRQ_RST = INT_COLD[B_MASTER] ^ ~CFG1_RST[B_POL];

  reg_addr_e wr_sel, rd_sel;
  assign wr_sel = reg_addr_e'(wr_addr_i);
  assign rd_sel = reg_addr_e'(rd_addr_i);

  logic [W-1:0] status_q, int_q, cfg1_q, cfg2_q, cmd_q;
  logic [W-1:0] status_n, int_n, cfg1_n, cfg2_n, cmd_n;
  logic         rdy_q, rdy_n, issue_q;
  logic [W-1:0] int_set, stat_set;
  logic         evt_rst, soft_rst, master_mid, upd_en;
  logic         cmd_take, cmd_issue, cmd_unknown;

  fics_evt_merge #(.W(W)) u_evt (
    .done_valid (done_valid_i),
    .done_kind  (done_kind_i),
    .done_err   (done_err_i),
    .int_set    (int_set),
    .stat_set   (stat_set),
    .evt_rst    (evt_rst)
  );

  assign soft_rst   = evt_rst | warm_rst_i;
  assign master_mid = soft_rst ? INT_WARM[B_MASTER]
                               : (int_q[B_MASTER] | int_set[B_MASTER]);

  fics_cmd_gate #(.W(W)) u_gate (
    .wr_cmd     (wr_en_i && (wr_sel == RA_CMD)),
    .code       (wr_data_i),
    .master_mid (master_mid),
    .take       (cmd_take),
    .issue      (cmd_issue),
    .unknown    (cmd_unknown)
  );

  // next state: completion/reset first, then the bus write on top
  always_comb begin
    status_n = status_q;
    int_n    = int_q;
    cfg1_n   = cfg1_q;
    cfg2_n   = cfg2_q;
    cmd_n    = cmd_q;
    rdy_n    = rdy_q;
    if (soft_rst) begin
      status_n = '0;
      int_n    = INT_WARM;
      cfg1_n   = CFG1_RST;
      cfg2_n   = '0;
      cmd_n    = '0;
      rdy_n    = 1'b1;
    end else begin
      status_n = status_n | stat_set;
      int_n    = int_n | int_set;
    end
    if (wr_en_i) begin
      case (wr_sel)
        RA_INTR: begin
          int_n = int_n & wr_data_i;
          if (!int_n[B_MASTER]) status_n = status_n & ~ERR_MASK;
        end
        RA_CFG1: begin
          cfg1_n = wr_data_i;
          rdy_n  = wr_data_i[B_RDY];
        end
        RA_CFG2: cfg2_n = wr_data_i;
        RA_CMD:  if (cmd_take) cmd_n = wr_data_i;
        default: ;
      endcase
    end
    if (cmd_unknown) begin
      status_n[B_ERR_CMD] = 1'b1;
      int_n[B_MASTER]     = 1'b1;
    end
  end

  assign upd_en = soft_rst | done_valid_i | wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      int_q    <= INT_COLD;
      cfg1_q   <= CFG1_RST;
      cfg2_q   <= '0;
      cmd_q    <= '0;
      rdy_q    <= 1'b1;
    end else if (upd_en) begin
      status_q <= status_n;
      int_q    <= int_n;
      cfg1_q   <= cfg1_n;
      cfg2_q   <= cfg2_n;
      cmd_q    <= cmd_n;
      rdy_q    <= rdy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issue_q <= 1'b0;
    else        issue_q <= cmd_issue;
  end

  fics_irq_drv #(.IRQ_RST(IRQ_RST)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .master (int_q[B_MASTER]),
    .pol    (cfg1_q[B_POL]),
    .irq_o  (irq_o)
  );

  always_comb begin
    case (rd_sel)
      RA_STATUS: rd_data_o = status_q;
      RA_INTR:   rd_data_o = int_q;
      RA_CFG1:   rd_data_o = cfg1_q & CFG1_RDMK;
      RA_CFG2:   rd_data_o = cfg2_q;
      RA_CMD:    rd_data_o = cmd_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign cmd_issue_o = issue_q;
  assign cmd_code_o  = cmd_q;
  assign rdy_o       = rdy_q;

  // R6
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel == RA_CMD && int_q[B_MASTER] && !soft_rst)
      |=> (!cmd_issue_o && cmd_code_o == $past(cmd_q)));

  // R5
  err_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel == RA_INTR && !wr_data_i[B_MASTER])
      |=> ((status_q & ERR_MASK) == '0));

  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid_i && done_err_i && done_kind_i != DONE_RESET && !warm_rst_i
     && !(wr_en_i && wr_sel == RA_INTR))
      |=> status_q[B_ERR_CMD]);

  // R3
  master_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid_i && done_kind_i != DONE_RESET && !warm_rst_i
     && !(wr_en_i && wr_sel == RA_INTR))
      |=> int_q[B_MASTER]);

  // R9
  rdy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel == RA_CFG1) |=> (rdy_o == $past(wr_data_i[B_RDY])));
endmodule

// File: tb/tb_flash_irq_status_ctrl.sv
module tb_flash_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst_i = 1'b0;
  logic        done_valid_i = 1'b0;
  logic [2:0]  done_kind_i = 3'd0;
  logic        done_err_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = 3'd0;
  logic [15:0] wr_data_i = 16'h0;
  logic [2:0]  rd_addr_i = 3'd0;
  logic [15:0] rd_data_o;
  logic        cmd_issue_o;
  logic [15:0] cmd_code_o;
  logic        irq_o, rdy_o;

  always #10 clk = ~clk;

  flash_irq_status_ctrl dut (.*);

  typedef struct {
    int          kind;   // 0 reg, 1 irq, 2 rdy, 3 issue
    logic [2:0]  addr;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   fin = 0;

  localparam logic [2:0] A_ST = 3'd0, A_IN = 3'd1, A_C1 = 3'd2, A_C2 = 3'd3, A_CM = 3'd4;
  localparam logic [2:0] K_LD = 3'd0, K_PG = 3'd1, K_ER = 3'd2, K_RS = 3'd3, K_OT = 3'd4;

  task automatic push(input int k, input logic [2:0] a, input logic [15:0] v, input string t);
    exp_t e;
    e.kind = k; e.addr = a; e.val = v; e.tag = t;
    q.push_back(e);
  endtask
  task automatic ereg(input logic [2:0] a, input logic [15:0] v, input string t);
    push(0, a, v, t);
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
    wr_en_i = 1'b0; done_valid_i = 1'b0; warm_rst_i = 1'b0; done_err_i = 1'b0;
  endtask
  task automatic set_wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
  endtask
  task automatic set_done(input logic [2:0] k, input logic e);
    done_valid_i = 1'b1; done_kind_i = k; done_err_i = e;
  endtask
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    set_wr(a, d); cyc();
  endtask
  task automatic done(input logic [2:0] k, input logic e);
    set_done(k, e); cyc();
  endtask

  // monitor: pops expectations between edges and compares
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t it;
        logic [15:0] act;
        it = q.pop_front();
        rd_addr_i = it.addr;
        #1;
        case (it.kind)
          0: act = rd_data_o;
          1: act = {15'b0, irq_o};
          2: act = {15'b0, rdy_o};
          default: act = {15'b0, cmd_issue_o};
        endcase
        checks++;
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 cold reset state
    ereg(A_ST, 16'h0000, "R1 status"); ereg(A_IN, 16'h8080, "R1 intr");
    ereg(A_C1, 16'h40C0, "R1 cfg1");   ereg(A_C2, 16'h0000, "R1 cfg2");
    ereg(A_CM, 16'h0000, "R1 cmd");
    push(2, 0, 16'h1, "R1 rdy"); push(1, 0, 16'h1, "R1 irq");
    // R6 command refused while master set
    wr(A_CM, 16'h0080);
    ereg(A_CM, 16'h0000, "R6 cmd kept"); push(3, 0, 16'h0, "R6 no issue");
    // R5 acknowledge, R8 delayed irq
    wr(A_IN, 16'h0000);
    ereg(A_IN, 16'h0000, "R5 intr ack"); push(1, 0, 16'h1, "R8 irq lag");
    cyc();
    push(1, 0, 16'h0, "R8 irq low");
    // R7 known command issued
    wr(A_CM, 16'h0080);
    ereg(A_CM, 16'h0080, "R7 cmd stored"); push(3, 0, 16'h1, "R7 issue");
    cyc();
    push(3, 0, 16'h0, "R7 issue one cycle");
    // R3 R4 program failure
    done(K_PG, 1'b1);
    ereg(A_IN, 16'h8040, "R3 prog"); ereg(A_ST, 16'h1400, "R4 prog err");
    cyc();
    push(1, 0, 16'h1, "R8 irq high");
    // R5 AND semantics
    wr(A_IN, 16'hFFFF);
    ereg(A_IN, 16'h8040, "R5 and keep"); ereg(A_ST, 16'h1400, "R5 err kept");
    wr(A_IN, 16'h7FFF);
    ereg(A_IN, 16'h0040, "R5 and clear"); ereg(A_ST, 16'h0000, "R5 err wiped");
    // R11 status read-only
    wr(A_ST, 16'h3C00);
    ereg(A_ST, 16'h0000, "R11 status ro");
    // R3 load ok
    done(K_LD, 1'b0);
    ereg(A_IN, 16'h80C0, "R3 load"); ereg(A_ST, 16'h0000, "R4 no err");
    wr(A_IN, 16'h0000);
    // R7 unknown command
    wr(A_CM, 16'h0055);
    ereg(A_CM, 16'h0055, "R7 unk stored"); push(3, 0, 16'h0, "R7 unk no issue");
    ereg(A_ST, 16'h0400, "R7 unk err"); ereg(A_IN, 16'h8000, "R7 unk master");
    wr(A_IN, 16'h0000);
    // R9 cfg1 / rdy, R8 polarity
    wr(A_C1, 16'h0000);
    ereg(A_C1, 16'h0000, "R9 cfg1"); push(2, 0, 16'h0, "R9 rdy low");
    push(1, 0, 16'h0, "R8 pol lag");
    cyc();
    push(1, 0, 16'h1, "R8 pol flip");
    wr(A_C1, 16'h00BF);
    ereg(A_C1, 16'h00A0, "R9 cfg1 mask"); push(2, 0, 16'h1, "R9 rdy high");
    wr(A_C2, 16'hBEEF);
    ereg(A_C2, 16'hBEEF, "R9 cfg2");
    // R3 R4 erase failure
    done(K_ER, 1'b1);
    ereg(A_IN, 16'h8020, "R3 erase"); ereg(A_ST, 16'h0C00, "R4 erase err");
    cyc();
    push(1, 0, 16'h0, "R8 active-low irq");
    // R10 completion + ack same cycle
    set_done(K_OT, 1'b1); set_wr(A_IN, 16'h0000); cyc();
    ereg(A_IN, 16'h0000, "R10 ack last"); ereg(A_ST, 16'h0000, "R10 err wiped");
    // R10 completion + command same cycle
    set_done(K_LD, 1'b0); set_wr(A_CM, 16'h0094); cyc();
    ereg(A_CM, 16'h0055, "R10 cmd refused"); push(3, 0, 16'h0, "R10 no issue");
    ereg(A_IN, 16'h8080, "R10 load int");
    wr(A_IN, 16'h0000);
    // R2 reset completion
    wr(A_C1, 16'h0040);
    push(2, 0, 16'h0, "R9 rdy low2");
    done(K_RS, 1'b0);
    ereg(A_IN, 16'h8010, "R2 intr"); ereg(A_C1, 16'h40C0, "R2 cfg1");
    ereg(A_C2, 16'h0000, "R2 cfg2"); ereg(A_ST, 16'h0000, "R2 status");
    ereg(A_CM, 16'h0000, "R2 cmd");   push(2, 0, 16'h1, "R2 rdy");
    // R2 warm reset input
    wr(A_IN, 16'h0000);
    wr(A_C2, 16'h1234);
    warm_rst_i = 1'b1; cyc();
    ereg(A_C2, 16'h0000, "R2 warm cfg2"); ereg(A_IN, 16'h8010, "R2 warm intr");
    // R10 reset completion + cfg1 write
    wr(A_IN, 16'h0000);
    set_done(K_RS, 1'b0); set_wr(A_C1, 16'h0085); cyc();
    ereg(A_C1, 16'h0080, "R10 cfg1 after reset"); ereg(A_IN, 16'h8010, "R10 reset int");
    push(2, 0, 16'h1, "R10 rdy");
    // R3 R4 kind other
    wr(A_IN, 16'h0000);
    done(K_OT, 1'b0);
    ereg(A_IN, 16'h8000, "R3 other"); ereg(A_ST, 16'h0000, "R4 other ok");
    done(K_OT, 1'b1);
    ereg(A_ST, 16'h0400, "R4 other err");
    @(negedge clk); #5;
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule